// File: doc/BRIEF.md
# Reconfigurable Approximate DCT Array

This block computes multiplierless approximate discrete cosine transforms on 32 signed samples at a time. Two mode pins set how the 32 lanes are grouped. The lanes can form one 32-point transform, two independent 16-point transforms, or four independent 8-point transforms. In every mode the block accepts one 32-sample vector per cycle and returns one 32-coefficient vector per cycle.

Four identical 8-point kernels do all the transform work. Each kernel uses only additions and subtractions. A larger transform is built by a butterfly stage that forms mirrored sums and differences. The sums go to one half-size transform and the differences go to another transform of the same kind, so the odd half is approximated with the even-half kernel. A 32-lane butterfly layer and a 16-lane butterfly layer either feed their results forward or pass their inputs through unchanged. An output permutation then interleaves the kernel results into natural coefficient order.

Data enters and leaves through a valid/ready stream. The mode travels with each vector. The whole pipeline advances only when its last stage is empty or is being consumed. Back-pressure therefore stalls every stage at once, and no vector is lost or repeated.

Top module: `adct_array`

## Requirements
- R1: The mode code {in_join_all, in_join_pair} selects the lane grouping.
  - 00 gives four 8-point transforms. Lanes 8g..8g+7 hold group g, and coefficient m of that group appears on lane 8g+m.
  - 01 gives two 16-point transforms, on lanes 0..15 and 16..31.
  - 11 gives one 32-point transform.
  - 10 behaves exactly like 11.
- R2: The 8-point kernel output m is the dot product of row m with the 8 samples. The rows, for m = 0 to 7, are:
  - row 0: 1,1,1,1,1,1,1,1
  - row 1: 1,1,1,1,-1,-1,-1,-1
  - row 2: 1,1,-1,-1,-1,-1,1,1
  - row 3: 1,-1,0,0,0,0,1,-1
  - row 4: 1,-1,-1,1,1,-1,-1,1
  - row 5: 0,0,1,-1,1,-1,0,0
  - row 6: 1,-1,1,-1,-1,1,-1,1
  - row 7: 1,-1,-1,1,-1,1,1,-1
- R3: An N-point transform (N = 16 or 32) of samples v is built from two N/2-point transforms.
  - Form s_i = v_i + v_(N-1-i) and d_i = v_i - v_(N-1-i) for i < N/2.
  - An even coefficient k equals coefficient k/2 of the transform of s.
  - An odd coefficient k equals coefficient (k-1)/2 of the transform of d.
- R4: Every accepted vector produces exactly one output vector, in acceptance order, at full precision with no rounding.
  - Input lane l occupies bits [8l+7:8l] of in_samples as an 8-bit signed value.
  - Output lane l occupies bits [13l+12:13l] of out_coef as a 13-bit signed value.
- R5: With PIPE=1 and no stall, a vector accepted at one clock edge appears on the output 7 edges later. With PIPE=0 the path is purely combinational.
- R6: The mode is captured with each vector and may change on every cycle without corrupting vectors already in flight.
- R7: The stream handshake follows two rules.
  - in_ready is high exactly when out_valid is low or out_ready is high.
  - While out_valid is high and out_ready is low, out_valid and out_coef stay unchanged.
- R8: A synchronous active-low reset empties the valid pipeline.
  - out_valid is low on the first cycle after reset and on every cycle after it until a new vector reaches the output.
  - Vectors that were in flight at reset are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Sample vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_join_all | input | 1 | Joins all four kernels into one 32-point transform |
| in_join_pair | input | 1 | Joins kernel pairs into 16-point transforms |
| in_samples | input | 256 | 32 signed samples, IW bits each |
| out_valid | output | 1 | Coefficient vector present |
| out_ready | input | 1 | Consumer takes the vector this cycle |
| out_coef | output | 416 | 32 signed coefficients, IW+5 bits each |

## Verification
The bench targets the following corner cases and the failure each one would expose.
- **Extreme inputs in 32-point mode.** All-maximum and all-minimum vectors in 32-point mode drive the DC lane to its range limit. A datapath that dropped a growth bit would wrap the sign.
- **Impulses and ramps in every mode.** A wrong permutation or a swapped butterfly half would misplace them in the odd lanes.
- **Mode changes on every cycle, including code 10.** A mode sampled at the pipeline input rather than carried with the data would mix groupings inside one vector.
- **Random back-pressure and a reset with vectors in flight.** These expose a stage that advances under stall, which would drop or duplicate a vector, and stale valid bits, which would emit a ghost vector after reset.

// File: rtl/adct_pkg.sv
package adct_pkg;
  localparam int LANES = 32;
  localparam int KPTS  = 8;

  // Lane feeding output position p of a 16-point group.
  function automatic int src16(int p);
    int h = p / 16;
    int j = p % 16;
    return 16 * h + (j % 2) * 8 + j / 2;
  endfunction

  // Lane feeding output position p of the 32-point transform.
  function automatic int src32(int p);
    int h = p % 2;
    int j = p / 2;
    return 16 * h + (j % 2) * 8 + j / 2;
  endfunction
endpackage

// File: rtl/adct_dly.sv
module adct_dly #(
  parameter int W    = 1,
  parameter bit PIPE = 1'b1,
  parameter bit RST  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (PIPE) begin : g_ff
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (RST && !rst_n) r <= '0;
      else if (en)       r <= d;
    end
    assign q = r;
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/adct_bfly.sv
module adct_bfly #(
  parameter int LANES = 32,
  parameter int N     = 32,
  parameter int IW    = 8,
  parameter bit PIPE  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    sel,
  input  logic [LANES-1:0][IW-1:0] din,
  output logic [LANES-1:0][IW:0]   dout
);
  localparam int GROUPS = LANES / N;
  localparam int HALF   = N / 2;

  logic [LANES-1:0][IW:0] mx;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar i = 0; i < HALF; i++) begin : g_pair
      localparam int LO = g * N + i;
      localparam int HI = g * N + N - 1 - i;
      logic [IW:0] a, b;
      assign a = {din[LO][IW-1], din[LO]};
      assign b = {din[HI][IW-1], din[HI]};
      assign mx[LO]        = sel ? a + b : a;
      assign mx[g*N+HALF+i] = sel ? a - b : {din[g*N+HALF+i][IW-1], din[g*N+HALF+i]};
    end
  end

  adct_dly #(.W(LANES*(IW+1)), .PIPE(PIPE), .RST(1'b0)) u_q (
    .clk(clk), .rst_n(rst_n), .en(en), .d(mx), .q(dout));

  if (PIPE) begin : g_chk
    // R1
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !sel |=> dout[0] == {$past(din[0][IW-1]), $past(din[0])});
    // R3
    pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && sel |=> ({dout[0][IW], dout[0]} + {dout[HALF][IW], dout[HALF]})
                    == {$past(din[0][IW-1]), $past(din[0]), 1'b0});
  end
endmodule

// File: rtl/adct_k8.sv
module adct_k8 #(
  parameter int IW   = 10,
  parameter bit PIPE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [7:0][IW-1:0]  x,
  output logic [7:0][IW+2:0]  y
);
  localparam int W1 = IW + 1;
  localparam int W2 = IW + 2;
  localparam int W3 = IW + 3;

  logic [7:0][W1-1:0] p1, q1;
  logic [7:0][W2-1:0] p2, q2;
  logic [7:0][W3-1:0] p3;

  // stage 1: mirrored sums (0..3) and differences (4..7)
  for (genvar i = 0; i < 4; i++) begin : g_s1
    assign p1[i]   = {x[i][IW-1], x[i]} + {x[7-i][IW-1], x[7-i]};
    assign p1[4+i] = {x[i][IW-1], x[i]} - {x[7-i][IW-1], x[7-i]};
  end
  adct_dly #(.W(8*W1), .PIPE(PIPE)) u_r1 (.clk(clk), .rst_n(rst_n), .en(en), .d(p1), .q(q1));

  // stage 2: two sum/diff pairs per half
  for (genvar h = 0; h < 2; h++) begin : g_s2
    localparam int B = 4 * h;
    logic [W2-1:0] e0, e1, e2, e3;
    assign e0 = {q1[B][W1-1],   q1[B]};
    assign e1 = {q1[B+1][W1-1], q1[B+1]};
    assign e2 = {q1[B+2][W1-1], q1[B+2]};
    assign e3 = {q1[B+3][W1-1], q1[B+3]};
    if (h == 0) begin : g_even
      assign p2[0] = e0 + e3;
      assign p2[1] = e1 + e2;
      assign p2[2] = e0 - e3;
      assign p2[3] = e1 - e2;
    end else begin : g_odd
      assign p2[4] = e0 + e1;
      assign p2[5] = e2 + e3;
      assign p2[6] = e0 - e1;
      assign p2[7] = e2 - e3;
    end
  end
  adct_dly #(.W(8*W2), .PIPE(PIPE)) u_r2 (.clk(clk), .rst_n(rst_n), .en(en), .d(p2), .q(q2));

  // stage 3: six adders, two straight wires
  logic [7:0][W3-1:0] f;
  for (genvar i = 0; i < 8; i++) begin : g_ext
    assign f[i] = {q2[i][W2-1], q2[i]};
  end
  assign p3[0] = f[0] + f[1];
  assign p3[4] = f[0] - f[1];
  assign p3[2] = f[2] + f[3];
  assign p3[6] = f[2] - f[3];
  assign p3[1] = f[4] + f[5];
  assign p3[7] = f[6] - f[7];
  assign p3[3] = f[6];
  assign p3[5] = f[7];
  adct_dly #(.W(8*W3), .PIPE(PIPE)) u_r3 (.clk(clk), .rst_n(rst_n), .en(en), .d(p3), .q(y));

  if (PIPE) begin : g_chk
    // R2
    even_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ({q2[0][W2-1], q2[0]} + {q2[2][W2-1], q2[2]})
             == {$past(q1[0][W1-1]), $past(q1[0]), 1'b0});
  end
endmodule

// File: rtl/adct_array.sv
module adct_array #(
  parameter int IW   = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_join_all,
  input  logic                 in_join_pair,
  input  logic [32*IW-1:0]     in_samples,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [32*(IW+5)-1:0] out_coef
);
  import adct_pkg::*;
  localparam int OW   = IW + 5;
  localparam int NSTG = 7;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // valid and mode travel together with the data
  logic [NSTG:0]        vq;
  logic [NSTG-1:0][1:0] mq;
  assign vq[0] = in_valid;
  assign mq[0] = {in_join_all, in_join_all | in_join_pair};
  for (genvar s = 0; s < NSTG; s++) begin : g_vld
    adct_dly #(.W(1), .PIPE(PIPE), .RST(1'b1)) u_v (
      .clk(clk), .rst_n(rst_n), .en(adv), .d(vq[s]), .q(vq[s+1]));
  end
  for (genvar s = 0; s < NSTG - 1; s++) begin : g_mode
    adct_dly #(.W(2), .PIPE(PIPE), .RST(1'b0)) u_m (
      .clk(clk), .rst_n(rst_n), .en(adv), .d(mq[s]), .q(mq[s+1]));
  end
  assign out_valid = vq[NSTG];

  logic [LANES-1:0][IW-1:0] x0, x1;
  logic [LANES-1:0][IW:0]   x2;
  logic [LANES-1:0][IW+1:0] x3;
  logic [LANES-1:0][OW-1:0] kq, pr, oc;

  assign x0 = in_samples;
  adct_dly #(.W(LANES*IW), .PIPE(PIPE)) u_in (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(x0), .q(x1));

  adct_bfly #(.LANES(LANES), .N(32), .IW(IW), .PIPE(PIPE)) u_b32 (
    .clk(clk), .rst_n(rst_n), .en(adv), .sel(mq[1][1]), .din(x1), .dout(x2));

  adct_bfly #(.LANES(LANES), .N(16), .IW(IW+1), .PIPE(PIPE)) u_b16 (
    .clk(clk), .rst_n(rst_n), .en(adv), .sel(mq[2][0]), .din(x2), .dout(x3));

  for (genvar g = 0; g < LANES / KPTS; g++) begin : g_kern
    adct_k8 #(.IW(IW+2), .PIPE(PIPE)) u_k (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .x(x3[KPTS*g +: KPTS]), .y(kq[KPTS*g +: KPTS]));
  end

  // output interleave: 3:1 choice per lane
  for (genvar p = 0; p < LANES; p++) begin : g_perm
    localparam int S16 = src16(p);
    localparam int S32 = src32(p);
    assign pr[p] = (mq[6] == 2'b00) ? kq[p] : (mq[6][1] ? kq[S32] : kq[S16]);
  end

  adct_dly #(.W(LANES*OW), .PIPE(PIPE)) u_out (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(pr), .q(oc));
  assign out_coef = oc;

  if (PIPE) begin : g_chk
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_coef));
    // R8
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);
    // R1
    perm8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv && mq[6] == 2'b00 |=> oc[3] == $past(kq[3]));
    // R3
    perm32_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv && mq[6] == 2'b11 |=> oc[1] == $past(kq[16]));
  end
endmodule

// File: tb/test_adct_array.sv
module test_adct_array;
  localparam int IW  = 8;
  localparam int OW  = IW + 5;
  localparam int L   = 32;
  localparam int LAT = 7;
  localparam int KM [8][8] = '{
    '{1, 1, 1, 1, 1, 1, 1, 1},
    '{1, 1, 1, 1,-1,-1,-1,-1},
    '{1, 1,-1,-1,-1,-1, 1, 1},
    '{1,-1, 0, 0, 0, 0, 1,-1},
    '{1,-1,-1, 1, 1,-1,-1, 1},
    '{0, 0, 1,-1, 1,-1, 0, 0},
    '{1,-1, 1,-1,-1, 1,-1, 1},
    '{1,-1,-1, 1,-1, 1, 1,-1}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_join_all, in_join_pair, out_valid, out_ready;
  logic [L*IW-1:0] in_samples;
  logic [L*OW-1:0] out_coef;

  adct_array #(.IW(IW), .PIPE(1'b1)) i_adct_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_join_all(in_join_all), .in_join_pair(in_join_pair), .in_samples(in_samples),
    .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef));

  int checks = 0, errors = 0, cyc = 0;
  int stim [L];
  int exp_q [$];
  int acc_q [$];
  int md_q  [$];
  bit lat_q [$];
  bit held = 1'b0;
  logic [L*OW-1:0] held_v;

  task automatic t8(input int v [8], output int o [8]);
    for (int r = 0; r < 8; r++) begin
      o[r] = 0;
      for (int c = 0; c < 8; c++) o[r] += KM[r][c] * v[c];
    end
  endtask

  task automatic t16(input int v [16], output int o [16]);
    int s [8]; int d [8]; int ys [8]; int yd [8];
    for (int i = 0; i < 8; i++) begin s[i] = v[i] + v[15-i]; d[i] = v[i] - v[15-i]; end
    t8(s, ys); t8(d, yd);
    for (int k = 0; k < 16; k++) o[k] = (k % 2 == 0) ? ys[k/2] : yd[k/2];
  endtask

  task automatic t32(input int v [32], output int o [32]);
    int s [16]; int d [16]; int ys [16]; int yd [16];
    for (int i = 0; i < 16; i++) begin s[i] = v[i] + v[31-i]; d[i] = v[i] - v[31-i]; end
    t16(s, ys); t16(d, yd);
    for (int k = 0; k < 32; k++) o[k] = (k % 2 == 0) ? ys[k/2] : yd[k/2];
  endtask

  // Reference for the current stimulus under mode code md (R1, R2, R3)
  task automatic ref_push(input int md);
    int res [32]; int v8 [8]; int o8 [8]; int v16 [16]; int o16 [16];
    if (md == 0) begin
      for (int g = 0; g < 4; g++) begin
        for (int i = 0; i < 8; i++) v8[i] = stim[8*g+i];
        t8(v8, o8);
        for (int i = 0; i < 8; i++) res[8*g+i] = o8[i];
      end
    end else if (md == 1) begin
      for (int h = 0; h < 2; h++) begin
        for (int i = 0; i < 16; i++) v16[i] = stim[16*h+i];
        t16(v16, o16);
        for (int i = 0; i < 16; i++) res[16*h+i] = o16[i];
      end
    end else begin
      t32(stim, res);
    end
    for (int l = 0; l < L; l++) exp_q.push_back(res[l]);
  endtask

  task automatic set_stim(input int kind, input int arg);
    for (int l = 0; l < L; l++) begin
      case (kind)
        0: stim[l] = 0;
        1: stim[l] = 127;
        2: stim[l] = -128;
        3: stim[l] = (l == arg % L) ? 100 : 0;
        4: stim[l] = 4 * l - 60;
        5: stim[l] = (l % 2 == 0) ? 127 : -128;
        default: stim[l] = int'($urandom_range(255)) - 128;
      endcase
    end
  endtask

  function automatic string tag(input int md);
    case (md)
      0: return "R1/R2 8-point";
      1: return "R3 16-point";
      2: return "R1 code 10 as 32-point";
      default: return "R3 32-point";
    endcase
  endfunction

  task automatic step(input bit rs, input bit iv, input int md, input bit ordy, input bit lf);
    int a; int e; int bad; int ba; int be; int ac; int pm; bit pl;
    @(negedge clk);
    rst_n = rs; in_valid = iv; out_ready = ordy;
    in_join_all = md[1]; in_join_pair = md[0];
    for (int l = 0; l < L; l++) in_samples[l*IW +: IW] = stim[l][IW-1:0];
    #1;
    if (!rs) begin cyc++; return; end
    // R7: output held under stall
    if (held) begin
      checks++;
      if (!out_valid || out_coef !== held_v) begin
        errors++;
        $display("FAIL R7 stalled output moved: valid=%0b coef=%h expected valid=1 coef=%h",
                 out_valid, out_coef, held_v);
      end
    end
    held = out_valid && !out_ready;
    held_v = out_coef;
    // R7: ready rule
    checks++;
    if (in_ready !== (!out_valid || out_ready)) begin
      errors++;
      $display("FAIL R7 in_ready=%0b expected %0b", in_ready, !out_valid || out_ready);
    end
    if (out_valid && out_ready) begin
      checks++;
      if (exp_q.size() < L) begin
        errors++;
        $display("FAIL R4 unexpected output vector: got valid=1 expected none");
      end else begin
        bad = -1; ba = 0; be = 0;
        pm = md_q.pop_front(); ac = acc_q.pop_front(); pl = lat_q.pop_front();
        for (int l = 0; l < L; l++) begin
          e = exp_q.pop_front();
          a = int'($signed(out_coef[l*OW +: OW]));
          if (a != e && bad < 0) begin bad = l; ba = a; be = e; end
        end
        if (bad >= 0) begin
          errors++;
          $display("FAIL %s (R4) lane %0d: got %0d expected %0d", tag(pm), bad, ba, be);
        end
        if (pl) begin
          checks++; // R5
          if (cyc - ac != LAT) begin
            errors++;
            $display("FAIL R5 latency got %0d expected %0d", cyc - ac, LAT);
          end
        end
      end
    end
    if (iv && in_ready) begin
      ref_push(md);
      md_q.push_back(md); acc_q.push_back(cyc); lat_q.push_back(lf);
    end
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 0, 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_join_all = 1'b0; in_join_pair = 1'b0; in_samples = '0;
    set_stim(0, 0);
    // R8: reset state
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 0, 1'b1, 1'b0);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R8 out_valid=%b in reset expected 0", out_valid); end
    end
    // R1 R2 R3 R5: directed patterns in every mode code
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 6; k++) begin
        set_stim(k, 5 * md + 3);
        step(1'b1, 1'b1, md, 1'b1, 1'b1);
      end
    end
    drain();
    // R3: impulse on every lane in 32-point mode
    for (int p = 0; p < L; p++) begin set_stim(3, p); step(1'b1, 1'b1, 3, 1'b1, 1'b1); end
    // R6: mode changes on every cycle
    for (int i = 0; i < 40; i++) begin set_stim(6, i); step(1'b1, 1'b1, i % 4, 1'b1, 1'b1); end
    drain();
    // R7: random back-pressure and gaps
    for (int i = 0; i < 400; i++) begin
      set_stim(6, i);
      step(1'b1, ($urandom_range(3) != 0), int'($urandom_range(3)), ($urandom_range(9) < 6), 1'b0);
    end
    drain();
    // R8: reset with vectors in flight
    for (int i = 0; i < 4; i++) begin set_stim(6, i); step(1'b1, 1'b1, 3, 1'b1, 1'b0); end
    step(1'b0, 1'b0, 0, 1'b1, 1'b0);
    exp_q.delete(); acc_q.delete(); md_q.delete(); lat_q.delete(); held = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, 0, 1'b1, 1'b0);
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R8 ghost output after reset: valid=%b expected 0", out_valid); end
    end
    for (int i = 0; i < 6; i++) begin set_stim(6, i); step(1'b1, 1'b1, i % 4, 1'b1, 1'b1); end
    drain();
    // R4: nothing left outstanding
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing outputs: got %0d pending expected 0", exp_q.size() / L);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule